// File: doc/BRIEF.md
# Cascadable Serial Step-Setting Port

This block holds an 8-bit step setting that picks one of 256 steps (codes 0 to 255). A bus master loads the setting over three control lines: a select line, a serial clock and a serial data input. While select is high, every rising serial clock edge shifts one new bit into an internal shift register and moves the previous contents one place toward the serial output. A master can therefore read the old setting back in the same transfer that writes the new one. The step setting that drives downstream logic stays as it was while bits shift in. It takes the shift register contents only when select falls.

The serial output drives only while select is high and floats at all other times. Because of this, several ports can be chained: each output feeds the next port's input, and all ports share the clock and select lines. A chain of N ports is rewritten without disturbance by shifting 8×N bits in one select window.

The three control lines are asynchronous to the system clock. They pass through a synchronizer of parameter depth, and serial clock edges are found by comparing samples. Reset clears both the shift register and the step setting to step 0.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset the step setting is 0, the serial output enable is 0, and the first transfer reads back eight zero bits.
- R2: Bits present on the serial input at rising serial clock edges while select is high enter most significant bit first. After 8 such edges and the fall of select, the step setting equals the 8 bits with the first bit as bit 7.
- R3: While select is high, the serial output presents the shift register's bit 7 before each rising serial clock edge. It therefore shows the previous setting MSB first: old bit 7 before the first edge, down to old bit 0 before the eighth.
- R4: The step setting does not change while select is high. It takes the shift register contents within a few system clocks after select falls.
- R5: The serial output enable is 1 while select is high and 0 while select is low, and the serial output is high-impedance whenever the enable is 0.
- R6: Serial clock edges while select is low change neither the step setting nor the shift register contents.
- R7: If select falls after K edges with K other than 8, the step setting takes the shift register as it stands. For K=3 that is the old value shifted left by 3, with the three new bits in bits 2..0.
- R8: With one port's serial output wired to a second port's serial input, an 8-bit transfer moves the first port's old contents into the second port. A 16-bit transfer leaves the first 8 bits in the second port and the last 8 in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, sampled by the system clock |
| ser_sel | input | 1 | Transfer select, active high |
| ser_din | input | 1 | Serial data input |
| ser_dout | output | 1 | Serial data output, high-impedance when not selected |
| ser_dout_oe | output | 1 | Drive enable of ser_dout |
| step_code | output | WIDTH | Active step setting |

## Verification
The assertions check, on every cycle, that a shift event takes the input bit and advances the old bits toward the output. They also check that the shift register does not move without a shift event, that the setting only changes at a select fall and then equals the shift register, and that shifts happen only while the output drives. Only the bench's scenarios can show the end-to-end behaviour. These are the readback order of the previous value across all 256 codes, commits after short transfers, the effect of clock edges outside select, and how data travels through a two-port chain.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef struct packed {
      logic sclk;
      logic sel;
      logic din;
   } ser_pins_t;

   typedef struct packed {
      logic shift;
      logic commit;
      logic drive;
   } ser_evt_t;
endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync
   import cfgport_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ser_pins_t pins_i,
   output ser_pins_t pins_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign pins_o = pins_i;
      end else begin : g_chain
         ser_pins_t pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= pins_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign pins_o = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfgport_events.sv
module cfgport_events
   import cfgport_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ser_pins_t pins,
   output ser_evt_t  evt
);
   logic prev_sclk, prev_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sclk <= 1'b0;
         prev_sel  <= 1'b0;
      end else begin
         prev_sclk <= pins.sclk;
         prev_sel  <= pins.sel;
      end
   end

   assign evt.shift  = pins.sel & pins.sclk & ~prev_sclk;
   assign evt.commit = ~pins.sel & prev_sel;
   assign evt.drive  = pins.sel;
endmodule

// File: rtl/cfgport_shifter.sv
module cfgport_shifter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic             din,
   output logic [WIDTH-1:0] sreg,
   output logic             msb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg <= '0;
      else if (shift) sreg <= {sreg[WIDTH-2:0], din};
   end

   assign msb = sreg[WIDTH-1];

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> sreg[0] == $past(din));
   assert_old_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> msb == $past(sreg[WIDTH-2]));
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(sreg));
endmodule

// File: rtl/cfgport_holder.sv
module cfgport_holder #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [WIDTH-1:0] staged,
   output logic [WIDTH-1:0] active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active <= '0;
      else if (commit) active <= staged;
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active));
   assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> active == $past(staged));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
   import cfgport_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_sel,
   input  logic             ser_din,
   output logic             ser_dout,
   output logic             ser_dout_oe,
   output logic [WIDTH-1:0] step_code
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("serial_cfg_port: WIDTH must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("serial_cfg_port: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   ser_pins_t        raw_pins, pins;
   ser_evt_t         evt;
   logic [WIDTH-1:0] sreg;
   logic             msb;

   assign raw_pins = '{sclk: ser_clk, sel: ser_sel, din: ser_din};

   cfgport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pins_i(raw_pins), .pins_o(pins));

   cfgport_events u_evt (
      .clk(clk), .rst_n(rst_n), .pins(pins), .evt(evt));

   cfgport_shifter #(.WIDTH(WIDTH)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift(evt.shift), .din(pins.din),
      .sreg(sreg), .msb(msb));

   cfgport_holder #(.WIDTH(WIDTH)) u_hold (
      .clk(clk), .rst_n(rst_n), .commit(evt.commit), .staged(sreg),
      .active(step_code));

   assign ser_dout_oe = evt.drive;
   assign ser_dout    = ser_dout_oe ? msb : 1'bz;

   assert_shift_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt.shift |-> ser_dout_oe);
   assert_commit_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt.commit |-> !ser_dout_oe);
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
   localparam int W = 8;
   localparam int SETTLE = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sel = 1'b0, din = 1'b0;
   logic dout_a, oe_a, dout_b, oe_b, din_b;
   logic [W-1:0] step_a, step_b;

   int checks = 0, fails = 0;
   logic [W-1:0] m_a = '0, m_b = '0, set_a = '0, set_b = '0;

   always #4 clk = ~clk;

   assign din_b = oe_a & dout_a;

   serial_cfg_port #(.WIDTH(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel(sel), .ser_din(din),
      .ser_dout(dout_a), .ser_dout_oe(oe_a), .step_code(step_a));

   serial_cfg_port #(.WIDTH(W), .SYNC_STAGES(2)) uut_b (
      .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_sel(sel), .ser_din(din_b),
      .ser_dout(dout_b), .ser_dout_oe(oe_b), .step_code(step_b));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic xfer(input logic [15:0] bits, input int n, input string rb_tag, input string end_tag);
      sel = 1'b1;
      settle();
      check("R5 oe while selected", oe_a, 1);
      for (int i = 0; i < n; i++) begin
         din = bits[n-1-i];
         settle();
         check(rb_tag, dout_a, m_a[W-1]);
         sclk = 1'b1;
         m_b = {m_b[W-2:0], m_a[W-1]};
         m_a = {m_a[W-2:0], bits[n-1-i]};
         settle();
         check("R4 setting held during shift", step_a, set_a);
         sclk = 1'b0;
         settle();
      end
      sel = 1'b0;
      settle();
      set_a = m_a;
      set_b = m_b;
      check(end_tag, step_a, set_a);
      check("R8 chained unit", step_b, set_b);
      check("R5 oe released", oe_a, 0);
   endtask

   initial begin
      repeat (5000000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 setting after reset", step_a, 0);
      check("R1 oe after reset", oe_a, 0);
      rst_n = 1'b1;
      settle();
      check("R1 setting after release", step_a, 0);
      check("R5 oe idle", oe_a, 0);

      // R1/R2/R3: first transfer reads zeros; then all 256 codes
      xfer(16'h00A5, 8, "R1 readback zeros", "R2 commit A5");
      for (int v = 0; v < 256; v++)
         xfer(16'(v), 8, "R3 readback previous", "R2 commit sweep");

      // R6: clock edges outside select are ignored
      for (int k = 0; k < 5; k++) begin
         din = k[0];
         sclk = 1'b1; settle();
         check("R5 oe low while deselected", oe_a, 0);
         sclk = 1'b0; settle();
      end
      check("R6 setting unchanged", step_a, set_a);
      xfer(16'h003C, 8, "R6 shift register unchanged", "R2 commit 3C");

      // R7: short and long transfers
      xfer(16'h0005, 3, "R3 readback short", "R7 short commit");
      check("R7 shifted-by-3 value", step_a, {8'h3C << 3} | 8'h05);
      xfer(16'h0001, 1, "R3 readback one", "R7 one-bit commit");
      xfer(16'h0000, 0, "R3 none", "R7 zero-bit commit");

      // R8: 16-bit transfer across the chain
      xfer(16'hC35A, 16, "R3 readback chain", "R8 first unit gets last byte");
      check("R8 first unit", step_a, 8'h5A);
      check("R8 second unit", step_b, 8'hC3);
      xfer(16'h0077, 8, "R8 readback", "R8 eight-bit push");
      check("R8 old value moved down", step_b, 8'h5A);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule